// File: doc/BRIEF.md
# Multi-Lane Odd-Parity Pixel Serializer

This block turns one parallel pixel word per frame period into a 30-bit serial frame. The word holds 24 colour bits and 3 control bits. The block adds an odd-parity bit and two zero bits, then sends the frame over one, two or three serial lanes. All logic runs on the fast bit clock. The pixel period is not a separate input: it is the frame length, 30, 15 or 10 bit clocks depending on how many lanes are in use. A pixel-clock replica is produced at that rate alongside the lanes.

A small controller holds two states. `ST_STANDBY` keeps every output low. `ST_STREAM` loads a frame, shifts it out, and at the last bit of each frame loads the next one back to back. There are three transitions:
- WAKE, from `ST_STANDBY` to `ST_STREAM`, when the enable input is seen high. This edge also captures the first frame.
- HALT, from `ST_STREAM` to `ST_STANDBY`, when the enable input is seen low. This clears the shift registers.
- RELOAD, from `ST_STREAM` to `ST_STREAM`, at the last bit of a frame while the enable input stays high.

The lane count and the lane-swap setting are captured together with the data at every frame load.

Top module: `pixser_top`

## Requirements
- R1: Frame bits are sent MSB first, in this order: ctl_i[2:0], then pix_i[23:0], then the parity bit, then two zero bits.
- R2: The parity bit makes the count of ones over ctl_i, pix_i and the parity bit odd. All-zero data gives parity 1. All-ones data gives parity 0.
- R3: lane_sel_i selects the lane count. 1, 2 and 3 select that many lanes, and 0 selects one lane. With N lanes the frame is cut into N consecutive groups of 30/N bits. Unswapped, group k is sent on lane_o[k].
- R4: Every lane_o bit at or above the active lane count stays 0.
- R5: frame_start_o is high during the first bit of each frame and low during all other bits. Frames follow each other every 30/N bit clocks.
- R6: pclk_o is high for the first ceil(L/2) bits of each frame and low for the remaining bits, where L = 30/N.
- R7: With swap_i = 1 and N active lanes, lane_o[j] carries group N-1-j.
- R8: Data, lane count and swap are captured only at a frame load. Changing them in the middle of a frame has no effect on that frame.
- R9: If enable_i is low at a clock edge, all lanes, pclk_o and frame_start_o are 0 after that edge. When enable_i is then seen high at an edge, a new frame is captured at that same edge, and its first bit appears right after it.
- R10: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Run (1) or standby (0) |
| lane_sel_i | input | 2 | Lane count: 1, 2 or 3 (0 selects 1) |
| swap_i | input | 1 | Reverse the order of the active lanes |
| pix_i | input | 24 | Colour bits |
| ctl_i | input | 3 | Control bits |
| lane_o | output | 3 | Serial lanes |
| pclk_o | output | 1 | Pixel-clock replica |
| frame_start_o | output | 1 | Marks the first bit of a frame |

## Verification
A wrong bit counter or a wrong group length shows at frame_start_o and pclk_o within one frame: the marker or the clock edge lands on the wrong bit. From that point every lane bit is misaligned. A wrong shift offset or a wrong swap index puts a bit from another group on a lane, starting with the first bit after the load. A configuration or data value taken mid-frame, instead of at the load, corrupts the bits of the frame in progress. A failed clear on HALT leaves a lane high in the cycle after enable_i drops.

// File: rtl/pixser_pkg.sv
package pixser_pkg;
    localparam int PIX_W     = 24;
    localparam int CTL_W     = 3;
    localparam int RSV_W     = 2;
    localparam int MAX_LANES = 3;
    localparam int DATA_W    = PIX_W + CTL_W;
    localparam int FRAME_W   = DATA_W + 1 + RSV_W;
    localparam int CNT_W     = $clog2(FRAME_W);

    typedef enum logic [0:0] {
        ST_STANDBY = 1'b0,
        ST_STREAM  = 1'b1
    } state_e;

    // group length in bit clocks for a normalised lane count
    function automatic logic [CNT_W-1:0] grp_len(input logic [1:0] lanes);
        case (lanes)
            2'd2:    return CNT_W'(FRAME_W / 2);
            2'd3:    return CNT_W'(FRAME_W / 3);
            default: return CNT_W'(FRAME_W);
        endcase
    endfunction
endpackage

// File: rtl/pixser_framer.sv
module pixser_framer #(
    parameter int PB = 24,
    parameter int CB = 3,
    parameter int RB = 2,
    localparam int FW = PB + CB + 1 + RB
) (
    input  logic [PB-1:0] pix_i,
    input  logic [CB-1:0] ctl_i,
    output logic [FW-1:0] frame_o
);
    logic par;

    // odd parity: the data bits plus the parity bit hold an odd count of ones
    assign par     = ~^{ctl_i, pix_i};
    assign frame_o = {ctl_i, pix_i, par, {RB{1'b0}}};
endmodule

// File: rtl/pixser_lane.sv
module pixser_lane #(
    parameter int FW = 30,
    parameter int OW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          load_i,
    input  logic          shift_i,
    input  logic [FW-1:0] frame_i,
    input  logic [OW-1:0] ofs_i,
    output logic          bit_o
);
    logic [FW-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (clear_i) begin
            sh_q <= '0;
        end else if (load_i) begin
            // left-align this lane's group so its first bit sits at the MSB
            sh_q <= frame_i << ofs_i;
        end else if (shift_i) begin
            sh_q <= {sh_q[FW-2:0], 1'b0};
        end
    end

    assign bit_o = sh_q[FW-1];
endmodule

// File: rtl/pixser_ctrl.sv
module pixser_ctrl
    import pixser_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic [1:0]    lane_sel_i,
    input  logic          swap_i,
    output logic          load_o,
    output logic          shift_o,
    output logic          clear_o,
    output logic [CW-1:0] load_len_o,
    output logic [1:0]    lanes_o,
    output logic          swap_o,
    output logic          frame_start_o,
    output logic          pclk_o
);
    state_e       st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d, len_q;
    logic [1:0]    lanes_q, sel_norm;
    logic          swap_q;

    assign sel_norm   = (lane_sel_i == 2'd0) ? 2'd1 : lane_sel_i;
    assign load_len_o = grp_len(sel_norm);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_STANDBY;
            cnt_q   <= '0;
            len_q   <= CW'(FRAME_W);
            lanes_q <= 2'd1;
            swap_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (load_o) begin
                lanes_q <= sel_norm;
                swap_q  <= swap_i;
                len_q   <= load_len_o;
            end
        end
    end

    // transitions
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        load_o  = 1'b0;
        shift_o = 1'b0;
        clear_o = 1'b0;
        unique case (st_q)
            ST_STANDBY: begin
                if (enable_i) begin          // WAKE
                    st_d   = ST_STREAM;
                    load_o = 1'b1;
                    cnt_d  = '0;
                end else begin
                    clear_o = 1'b1;
                end
            end
            ST_STREAM: begin
                if (!enable_i) begin         // HALT
                    st_d    = ST_STANDBY;
                    clear_o = 1'b1;
                    cnt_d   = '0;
                end else if (cnt_q == len_q - CW'(1)) begin  // RELOAD
                    load_o = 1'b1;
                    cnt_d  = '0;
                end else begin
                    shift_o = 1'b1;
                    cnt_d   = cnt_q + CW'(1);
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        lanes_o       = lanes_q;
        swap_o        = swap_q;
        frame_start_o = 1'b0;
        pclk_o        = 1'b0;
        unique case (st_q)
            ST_STANDBY: ;
            ST_STREAM: begin
                frame_start_o = (cnt_q == '0);
                pclk_o        = (cnt_q < ((len_q + CW'(1)) >> 1));
            end
        endcase
    end
endmodule

// File: rtl/pixser_top.sv
module pixser_top
    import pixser_pkg::*;
#(
    parameter int PIX_BITS = PIX_W,
    parameter int CTL_BITS = CTL_W,
    parameter int LANES    = MAX_LANES,
    localparam int FW = PIX_BITS + CTL_BITS + 1 + RSV_W,
    localparam int CW = $clog2(FW),
    localparam int OW = CW + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable_i,
    input  logic [1:0]          lane_sel_i,
    input  logic                swap_i,
    input  logic [PIX_BITS-1:0] pix_i,
    input  logic [CTL_BITS-1:0] ctl_i,
    output logic [LANES-1:0]    lane_o,
    output logic                pclk_o,
    output logic                frame_start_o
);
    logic [FW-1:0]    frame_w;
    logic             load_w, shift_w, clear_w, swap_q;
    logic [CW-1:0]    load_len;
    logic [1:0]       lanes_q;
    logic [LANES-1:0] grp_bit;

    pixser_framer #(.PB(PIX_BITS), .CB(CTL_BITS), .RB(RSV_W)) framer_i (
        .pix_i   (pix_i),
        .ctl_i   (ctl_i),
        .frame_o (frame_w)
    );

    pixser_ctrl #(.CW(CW)) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (enable_i),
        .lane_sel_i    (lane_sel_i),
        .swap_i        (swap_i),
        .load_o        (load_w),
        .shift_o       (shift_w),
        .clear_o       (clear_w),
        .load_len_o    (load_len),
        .lanes_o       (lanes_q),
        .swap_o        (swap_q),
        .frame_start_o (frame_start_o),
        .pclk_o        (pclk_o)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [OW-1:0] ofs;
        assign ofs = OW'(k) * OW'(load_len);
        pixser_lane #(.FW(FW), .OW(OW)) lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (clear_w),
            .load_i  (load_w),
            .shift_i (shift_w),
            .frame_i (frame_w),
            .ofs_i   (ofs),
            .bit_o   (grp_bit[k])
        );
    end

    // route groups to output lanes, reversed among the active lanes on swap
    always_comb begin
        lane_o = '0;
        for (int j = 0; j < LANES; j++) begin
            if (j < int'(lanes_q)) begin
                if (swap_q) lane_o[j] = grp_bit[int'(lanes_q) - 1 - j];
                else        lane_o[j] = grp_bit[j];
            end
        end
    end
endmodule

// File: rtl/pixser_checker.sv
module pixser_checker #(
    parameter int LANES = 3,
    parameter int FW    = 30,
    parameter int RB    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable_i,
    input logic [LANES-1:0] lane_o,
    input logic             pclk_o,
    input logic             frame_start_o,
    input logic [1:0]       lanes_q,
    input logic [FW-1:0]    frame_w
);
    p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (lane_o == '0 && !pclk_o && !frame_start_o));

    p_wake_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(enable_i) && !frame_start_o && !pclk_o) |=> frame_start_o);

    p_single_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |=> !frame_start_o);

    p_clock_at_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> pclk_o);

    p_unused_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lanes_q == 2'd1) |-> (lane_o[LANES-1:1] == '0));

    p_odd_parity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(frame_w[FW-1:RB]) % 2) == 1);
endmodule

bind pixser_top pixser_checker chk_i (.*);

// File: tb/pixser_top_tb_top.sv
module pixser_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable_i;
    logic [1:0]  lane_sel_i;
    logic        swap_i;
    logic [23:0] pix_i;
    logic [2:0]  ctl_i;
    logic [2:0]  lane_o;
    logic        pclk_o;
    logic        frame_start_o;

    int n_tests = 0;
    int n_fail  = 0;
    int frame_no = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pixser_top dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (enable_i),
        .lane_sel_i    (lane_sel_i),
        .swap_i        (swap_i),
        .pix_i         (pix_i),
        .ctl_i         (ctl_i),
        .lane_o        (lane_o),
        .pclk_o        (pclk_o),
        .frame_start_o (frame_start_o)
    );

    function automatic logic [29:0] exp_frame(input logic [23:0] p, input logic [2:0] c);
        int ones = 0;
        for (int i = 0; i < 24; i++) ones += int'(p[i]);
        for (int i = 0; i < 3; i++) ones += int'(c[i]);
        return {c, p, (ones % 2 == 0) ? 1'b1 : 1'b0, 2'b00};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d frame=%0d", tag, act, exp, frame_no);
        end
    endtask

    task automatic next_inputs();
        frame_no++;
        case (frame_no)
            1: begin pix_i = '0; ctl_i = '0; lane_sel_i = 2'd1; swap_i = 1'b0; end
            2: begin pix_i = '1; ctl_i = '1; lane_sel_i = 2'd2; swap_i = 1'b1; end
            3: begin pix_i = 24'hA5C30F; ctl_i = 3'b101; lane_sel_i = 2'd0; swap_i = 1'b1; end
            4: begin pix_i = 24'h123456; ctl_i = 3'b010; lane_sel_i = 2'd3; swap_i = 1'b1; end
            5: begin pix_i = 24'h800001; ctl_i = 3'b100; lane_sel_i = 2'd3; swap_i = 1'b0; end
            default: begin
                pix_i      = 24'($urandom);
                ctl_i      = 3'($urandom);
                lane_sel_i = 2'($urandom);
                swap_i     = 1'($urandom);
            end
        endcase
    endtask

    // call at the negedge of a frame's first bit; leaves the bench there for the next frame
    task automatic play(input int nframes, input bit mid_change);
        for (int f = 0; f < nframes; f++) begin
            int n, len;
            bit sw;
            logic [29:0] frm;
            n   = (lane_sel_i == 2'd0) ? 1 : int'(lane_sel_i);
            sw  = swap_i;
            frm = exp_frame(pix_i, ctl_i);
            len = 30 / n;
            for (int b = 0; b < len; b++) begin
                for (int j = 0; j < 3; j++) begin
                    int grp;
                    logic e;
                    grp = sw ? (n - 1 - j) : j;
                    e = (j < n) ? frm[29 - grp * len - b] : 1'b0;
                    if (j >= n)          chk(lane_o[j] == e, "R4 unused lane", int'(lane_o[j]), int'(e));
                    else if (sw && n > 1) chk(lane_o[j] == e, "R7 swapped lane", int'(lane_o[j]), int'(e));
                    else if (n > 1)      chk(lane_o[j] == e, "R3 lane group", int'(lane_o[j]), int'(e));
                    else                 chk(lane_o[j] == e, "R1 frame bit", int'(lane_o[j]), int'(e));
                end
                chk(frame_start_o == (b == 0), "R5 frame marker", int'(frame_start_o), int'(b == 0));
                chk(pclk_o == (b < (len + 1) / 2), "R6 pixel clock", int'(pclk_o), int'(b < (len + 1) / 2));
                if (mid_change && b == 2) begin   // R8: must not disturb the frame in flight
                    pix_i      = ~pix_i;
                    ctl_i      = ~ctl_i;
                    lane_sel_i = lane_sel_i + 2'd1;
                    swap_i     = ~swap_i;
                end
                if (b == len - 1) next_inputs();
                @(negedge clk);
            end
        end
    endtask

    task automatic check_quiet(input string tag);
        chk(lane_o == 3'b000, tag, int'(lane_o), 0);
        chk(!pclk_o && !frame_start_o, tag, int'({pclk_o, frame_start_o}), 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; enable_i = 1'b1; lane_sel_i = 2'd1; swap_i = 1'b0;
        pix_i = '1; ctl_i = '1;
        repeat (3) @(negedge clk);
        check_quiet("R10 reset");
        enable_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R9 standby");

        // R2 parity of corner words
        chk(exp_frame('0, '0)[2] == 1'b1, "R2 zero parity", int'(exp_frame('0, '0)[2]), 1);
        chk(exp_frame('1, '1)[2] == 1'b0, "R2 ones parity", int'(exp_frame('1, '1)[2]), 0);

        next_inputs();
        enable_i = 1'b1;
        @(negedge clk);                    // R9 first bit right after wake edge
        chk(frame_start_o == 1'b1, "R9 wake start", int'(frame_start_o), 1);
        play(12, 1'b0);
        play(10, 1'b1);

        // mid-frame halt
        repeat (4) @(negedge clk);
        enable_i = 1'b0;
        @(negedge clk);
        check_quiet("R9 halt");
        repeat (3) begin
            @(negedge clk);
            check_quiet("R9 held low");
        end
        enable_i = 1'b1;
        @(negedge clk);
        chk(frame_start_o == 1'b1, "R9 restart", int'(frame_start_o), 1);
        play(15, 1'b1);
        play(10, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule